// File: doc/BRIEF.md
# Program Counter Sequencer with Zero-Overhead Repeat

This block owns the program counter of a small processor front end. The counter advances in 32-bit instruction words; the block turns it into a byte fetch address by scaling it by four and tests that address against a window of addresses that a program image has filled. An address outside the window stops sequencing with an illegal-fetch exception code. A single-step mode stops sequencing with a trap code after one instruction word.

Execute reports each retired instruction word with the program counter it wants next. When that value is the same as the current counter, the block moves on by one word. A hardware repeat loop sits between execute and the counter. It holds a loop start, a loop end and an iteration count. Each time the loop-end word retires, it takes one from the count and sends the counter back to the loop start. When the count runs out, the loop switches itself off.

Software loads the window by reporting each image write, and arms a loop through a setup write port. A start request with a byte address begins a run. Once an exception code is raised, the counter and loop state stay as they are until a new start or a reset.

Top module: `pc_repeat_seq`

## Requirements
- R1: `fetch_addr` always equals `pc` multiplied by four: `pc` sits in the upper bits and the two low bits are zero.
- R2: A start request loads `pc` with `start_byte_addr` shifted right by two, clears `exc_code` to 00, switches the repeat loop off and enables sequencing. All of this is visible after the next clock edge, and a start has priority over every other input in that cycle.
- R3: After reset the window lower bound is all ones and the upper bound is zero. An image write with a non-zero length lowers the lower bound to the write address if that is smaller. It raises the upper bound to address plus length minus one if that is larger, saturating at all ones. A zero-length write changes nothing.
- R4: While sequencing with `exc_code` 00, a fetch address below the lower bound or above the upper bound sets `exc_code` to 01 at the next edge. An execute report in that cycle is ignored.
- R5: An accepted execute report (sequencing, `exc_code` 00, fetch in window) sets `pc` to the candidate address after the repeat stage, or to `pc`+1 when that candidate equals the current `pc`.
- R6: With the loop on, an execute report whose next address equals the loop end decrements the count. If the count was above one, the candidate becomes the loop start. If the count was one, the loop switches off and the reported address goes on to the R5 rule.
- R7: A loop setup write loads start, end and count, and switches the loop on exactly when the count is non-zero. When it comes in the same cycle as a loop-end decrement, the write decides the stored loop state, but the redirect in that cycle still uses the old settings.
- R8: An accepted execute report with `step_mode` high updates `pc` as usual and sets `exc_code` to 10 at the same edge.
- R9: While `exc_code` is non-zero, `pc`, `exc_code` and the loop count hold their values and execute reports are ignored, until a start or a reset.
- R10: Reset sets `pc` to 0 and `exc_code` to 00 and leaves sequencing disabled. Execute reports are ignored until the first start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Begin a run at `start_byte_addr` |
| start_byte_addr | input | PC_W+2 | Byte address of the first instruction word |
| img_wr_valid | input | 1 | A program image write took place |
| img_wr_addr | input | PC_W+2 | Byte address of the image write |
| img_wr_len | input | LEN_W | Byte length of the image write |
| loop_wr_valid | input | 1 | Loop setup write |
| loop_wr_start | input | PC_W | Word address of the first loop word |
| loop_wr_end | input | PC_W | Word address of the last loop word |
| loop_wr_count | input | CNT_W | Number of loop passes; zero leaves the loop off |
| exec_valid | input | 1 | Execute retired the word at `pc` |
| exec_next_pc | input | PC_W | Next word address requested by execute |
| step_mode | input | 1 | Trap after the next retired word |
| fetch_addr | output | PC_W+2 | Byte fetch address |
| pc | output | PC_W | Word program counter |
| exc_code | output | 2 | 00 none, 01 illegal fetch, 10 step trap |

## Verification
The bench runs a two-pass loop all the way through. A design that counts the last pass wrongly runs one pass too many, or falls out one word early. It arms a loop in the same cycle as a loop-end retirement, where a wrong priority leaves a stale count and sends a later pass back to the old start. It also tries a zero-count setup, which must not make a loop. It probes the window exactly at its upper byte, one word past it and one word under the lower bound. An off-by-one compare would miss the fault or raise it on a legal word. Finally it sends execute reports while idle, while faulted and in the same cycle a fault is detected: a design that does not freeze would move `pc` there.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

    typedef enum logic [1:0] {
        EXC_NONE    = 2'b00,
        EXC_ILLEGAL = 2'b01,
        EXC_TRAP    = 2'b10
    } exc_e;

    typedef struct packed {
        logic launch;   // start request this cycle
        logic live;     // sequencing and no exception pending
        logic fault;    // live but fetch outside window
        logic accept;   // execute report taken
    } seq_ctl_t;

    function automatic exc_e settle_exc(seq_ctl_t c, logic step, exc_e cur);
        if (c.launch)
            return EXC_NONE;
        else if (c.fault)
            return EXC_ILLEGAL;
        else if (c.accept && step)
            return EXC_TRAP;
        else
            return cur;
    endfunction

endpackage

// File: rtl/pcseq_window.sv
module pcseq_window #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              out_of_range
);
    localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] lo_q, hi_q;
    logic [ADDR_W:0]   last_wide;
    logic [ADDR_W-1:0] last_addr;

    always_comb begin
        last_wide = {1'b0, wr_addr} + {{(ADDR_W+1-LEN_W){1'b0}}, wr_len} - 1'b1;
        last_addr = last_wide[ADDR_W] ? TOP : last_wide[ADDR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= TOP;
            hi_q <= '0;
        end else if (wr_valid && (wr_len != '0)) begin
            if (wr_addr < lo_q)
                lo_q <= wr_addr;
            if (last_addr > hi_q)
                hi_q <= last_addr;
        end
    end

    assign out_of_range = (probe_addr < lo_q) || (probe_addr > hi_q);

endmodule

// File: rtl/pcseq_repeat.sv
module pcseq_repeat #(
    parameter int PC_W  = 14,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             cfg_wr,
    input  logic [PC_W-1:0]  cfg_start,
    input  logic [PC_W-1:0]  cfg_end,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             advance,
    input  logic [PC_W-1:0]  cand_pc,
    output logic [PC_W-1:0]  redirect_pc,
    output logic             active
);
    logic [PC_W-1:0]  start_q, end_q;
    logic [CNT_W-1:0] count_q;
    logic             active_q;
    logic             hit, final_pass;

    always_comb begin
        hit         = active_q && (cand_pc == end_q);
        final_pass  = (count_q == CNT_W'(1));
        redirect_pc = (hit && !final_pass) ? start_q : cand_pc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q  <= '0;
            end_q    <= '0;
            count_q  <= '0;
            active_q <= 1'b0;
        end else if (clear) begin
            active_q <= 1'b0;
        end else if (cfg_wr) begin
            start_q  <= cfg_start;
            end_q    <= cfg_end;
            count_q  <= cfg_count;
            active_q <= (cfg_count != '0);
        end else if (advance && hit) begin
            count_q <= count_q - 1'b1;
            if (final_pass)
                active_q <= 1'b0;
        end
    end

    assign active = active_q;

endmodule

// File: rtl/pc_repeat_seq.sv
module pc_repeat_seq
    import pcseq_pkg::*;
#(
    parameter int PC_W  = 14,
    parameter int CNT_W = 8,
    parameter int LEN_W = 8,
    localparam int ADDR_W = PC_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_valid,
    input  logic [ADDR_W-1:0] start_byte_addr,
    input  logic              img_wr_valid,
    input  logic [ADDR_W-1:0] img_wr_addr,
    input  logic [LEN_W-1:0]  img_wr_len,
    input  logic              loop_wr_valid,
    input  logic [PC_W-1:0]   loop_wr_start,
    input  logic [PC_W-1:0]   loop_wr_end,
    input  logic [CNT_W-1:0]  loop_wr_count,
    input  logic              exec_valid,
    input  logic [PC_W-1:0]   exec_next_pc,
    input  logic              step_mode,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [PC_W-1:0]   pc,
    output logic [1:0]        exc_code
);
    logic [PC_W-1:0] pc_q, redirect_pc, next_pc;
    exc_e            exc_q;
    logic            running_q;
    logic            oob, loop_on;
    seq_ctl_t        ctl;

    assign fetch_addr = {pc_q, 2'b00};

    always_comb begin
        ctl.launch = start_valid;
        ctl.live   = !start_valid && running_q && (exc_q == EXC_NONE);
        ctl.fault  = ctl.live && oob;
        ctl.accept = ctl.live && !oob && exec_valid;
    end

    pcseq_window #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) win_i (
        .clk          (clk),
        .rst          (rst),
        .wr_valid     (img_wr_valid),
        .wr_addr      (img_wr_addr),
        .wr_len       (img_wr_len),
        .probe_addr   (fetch_addr),
        .out_of_range (oob)
    );

    pcseq_repeat #(.PC_W(PC_W), .CNT_W(CNT_W)) rpt_i (
        .clk         (clk),
        .rst         (rst),
        .clear       (start_valid),
        .cfg_wr      (loop_wr_valid),
        .cfg_start   (loop_wr_start),
        .cfg_end     (loop_wr_end),
        .cfg_count   (loop_wr_count),
        .advance     (ctl.accept),
        .cand_pc     (exec_next_pc),
        .redirect_pc (redirect_pc),
        .active      (loop_on)
    );

    assign next_pc = (redirect_pc == pc_q) ? pc_q + 1'b1 : redirect_pc;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q      <= '0;
            exc_q     <= EXC_NONE;
            running_q <= 1'b0;
        end else begin
            exc_q <= settle_exc(ctl, step_mode, exc_q);
            if (ctl.launch) begin
                pc_q      <= start_byte_addr[ADDR_W-1:2];
                running_q <= 1'b1;
            end else if (ctl.accept) begin
                pc_q <= next_pc;
            end
        end
    end

    assign pc       = pc_q;
    assign exc_code = exc_q;

endmodule

// File: rtl/pc_repeat_seq_checker.sv
module pc_repeat_seq_checker #(
    parameter int PC_W = 14
) (
    input logic            clk,
    input logic            rst,
    input logic            start_valid,
    input logic [PC_W+1:0] start_byte_addr,
    input logic            exec_valid,
    input logic            step_mode,
    input logic [PC_W-1:0] pc,
    input logic [1:0]      exc_code,
    input logic            oob,
    input logic            running_q
);
    assert_start_load_R2: assert property (@(posedge clk) disable iff (rst)
        start_valid |=> (pc == $past(start_byte_addr[PC_W+1:2])) && (exc_code == 2'b00));

    assert_window_fault_R4: assert property (@(posedge clk) disable iff (rst)
        (running_q && exc_code == 2'b00 && oob && !start_valid)
        |=> (exc_code == 2'b01) && $stable(pc));

    assert_step_trap_R8: assert property (@(posedge clk) disable iff (rst)
        (running_q && exc_code == 2'b00 && !oob && exec_valid && step_mode && !start_valid)
        |=> (exc_code == 2'b10));

    assert_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        (exc_code != 2'b00 && !start_valid) |=> $stable(pc) && $stable(exc_code));

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (!running_q && !start_valid) |=> $stable(pc) && (exc_code == 2'b00));

endmodule

bind pc_repeat_seq pc_repeat_seq_checker #(.PC_W(PC_W)) chk_i (
    .clk             (clk),
    .rst             (rst),
    .start_valid     (start_valid),
    .start_byte_addr (start_byte_addr),
    .exec_valid      (exec_valid),
    .step_mode       (step_mode),
    .pc              (pc),
    .exc_code        (exc_code),
    .oob             (oob),
    .running_q       (running_q)
);

// File: tb/pc_repeat_seq_tb_top.sv
`timescale 1ns/1ps
module pc_repeat_seq_tb_top;
    localparam int PC_W = 14, CNT_W = 8, LEN_W = 8, ADDR_W = PC_W + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic              start_valid = 0, img_wr_valid = 0, loop_wr_valid = 0;
    logic              exec_valid = 0, step_mode = 0;
    logic [ADDR_W-1:0] start_byte_addr = '0, img_wr_addr = '0;
    logic [LEN_W-1:0]  img_wr_len = '0;
    logic [PC_W-1:0]   loop_wr_start = '0, loop_wr_end = '0, exec_next_pc = '0;
    logic [CNT_W-1:0]  loop_wr_count = '0;
    logic [ADDR_W-1:0] fetch_addr;
    logic [PC_W-1:0]   pc;
    logic [1:0]        exc_code;

    pc_repeat_seq #(.PC_W(PC_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) dut_i (.*);

    int checks = 0, errors = 0;

    // stimulus staging
    logic              s_st, s_iw, s_lw, s_ev, s_sm;
    logic [ADDR_W-1:0] s_sa, s_ia;
    logic [LEN_W-1:0]  s_il;
    logic [PC_W-1:0]   s_ls, s_le, s_np;
    logic [CNT_W-1:0]  s_lc;

    // reference model state
    logic [PC_W-1:0]   m_pc, m_s, m_e;
    logic [1:0]        m_exc;
    logic [CNT_W-1:0]  m_c;
    logic              m_act, m_run;
    logic [ADDR_W-1:0] m_min, m_max;

    typedef struct {
        logic [PC_W-1:0] pc;
        logic [1:0]      exc;
        string           tag;
    } exp_t;
    exp_t q[$];

    task automatic clear_stim();
        s_st = 0; s_iw = 0; s_lw = 0; s_ev = 0; s_sm = 0;
        s_sa = '0; s_ia = '0; s_il = '0; s_ls = '0; s_le = '0; s_np = '0; s_lc = '0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic tick(input string tag);
        logic [ADDR_W-1:0] byte_a;
        logic [PC_W-1:0]   cand;
        logic [ADDR_W:0]   last;
        logic              hit, ill;
        @(negedge clk);
        start_valid = s_st; start_byte_addr = s_sa;
        img_wr_valid = s_iw; img_wr_addr = s_ia; img_wr_len = s_il;
        loop_wr_valid = s_lw; loop_wr_start = s_ls; loop_wr_end = s_le; loop_wr_count = s_lc;
        exec_valid = s_ev; exec_next_pc = s_np; step_mode = s_sm;
        byte_a = {m_pc, 2'b00};
        ill = m_run && (m_exc == 2'b00) && ((byte_a < m_min) || (byte_a > m_max));
        if (s_st) begin
            m_pc = s_sa[ADDR_W-1:2]; m_exc = 2'b00; m_run = 1; m_act = 0;
        end else begin
            if (m_run && m_exc == 2'b00) begin
                if (ill) m_exc = 2'b01;
                else if (s_ev) begin
                    cand = s_np;
                    hit = m_act && (cand == m_e);
                    if (hit && m_c != 1) cand = m_s;
                    if (cand == m_pc) cand = m_pc + 1'b1;
                    if (hit && !s_lw) begin
                        m_c = m_c - 1'b1;
                        if (m_c == 0) m_act = 0;
                    end
                    m_pc = cand;
                    if (s_sm) m_exc = 2'b10;
                end
            end
            if (s_lw) begin
                m_s = s_ls; m_e = s_le; m_c = s_lc; m_act = (s_lc != 0);
            end
        end
        if (s_iw && s_il != 0) begin
            last = {1'b0, s_ia} + {{(ADDR_W+1-LEN_W){1'b0}}, s_il} - 1'b1;
            if (last[ADDR_W]) last = {1'b0, {ADDR_W{1'b1}}};
            if (s_ia < m_min) m_min = s_ia;
            if (last[ADDR_W-1:0] > m_max) m_max = last[ADDR_W-1:0];
        end
        q.push_back('{m_pc, m_exc, tag});
        clear_stim();
    endtask

    // monitor: pops expected items and compares with the outputs
    always @(posedge clk) begin
        exp_t e;
        #2;
        if (q.size() != 0) begin
            e = q.pop_front();
            chk({e.tag, " pc"}, 32'(pc), 32'(e.pc));
            chk({e.tag, " exc"}, 32'(exc_code), 32'(e.exc));
            chk("R1 fetch address", 32'(fetch_addr), 32'({pc, 2'b00}));
        end
    end

    task automatic run_exec(input string tag, input logic [PC_W-1:0] np);
        s_ev = 1; s_np = np; tick(tag);
    endtask

    initial begin
        clear_stim();
        m_pc = '0; m_exc = 2'b00; m_run = 0; m_act = 0; m_s = '0; m_e = '0; m_c = '0;
        m_min = {ADDR_W{1'b1}}; m_max = '0;
        repeat (3) @(posedge clk);
        #2;
        chk("R10 reset pc", 32'(pc), 0);
        chk("R10 reset exc", 32'(exc_code), 0);
        chk("R1 reset fetch", 32'(fetch_addr), 0);
        @(negedge clk); rst = 0;

        run_exec("R10 exec ignored while idle", 14'h5);
        // window: 0x100..0x13F, then lower bound 0x80, zero length ignored
        s_iw = 1; s_ia = 16'h0100; s_il = 8'h40; tick("R3 image write");
        s_iw = 1; s_ia = 16'h0080; s_il = 8'h10; tick("R3 image write low");
        s_iw = 1; s_ia = 16'h0000; s_il = 8'h00; tick("R3 zero length");
        s_st = 1; s_sa = 16'h0107; tick("R2 start unaligned");
        run_exec("R5 fall through", 14'h41);
        run_exec("R5 branch", 14'h4A);
        run_exec("R5 branch back", 14'h41);
        // two-pass loop 0x41..0x43
        s_lw = 1; s_ls = 14'h41; s_le = 14'h43; s_lc = 8'd2; tick("R7 loop setup");
        run_exec("R6 pass1", 14'h41);
        run_exec("R6 pass1", 14'h42);
        run_exec("R6 loop back", 14'h43);
        run_exec("R6 pass2", 14'h41);
        run_exec("R6 pass2", 14'h42);
        run_exec("R6 loop exit", 14'h43);
        run_exec("R6 inactive branch", 14'h43);
        run_exec("R6 inactive no repeat", 14'h43);
        // zero count never arms
        s_lw = 1; s_ls = 14'h41; s_le = 14'h45; s_lc = 8'd0; tick("R7 zero count");
        run_exec("R7 zero count step", 14'h44);
        run_exec("R7 zero count no loop", 14'h45);
        // setup write versus same-cycle decrement
        s_lw = 1; s_ls = 14'h41; s_le = 14'h47; s_lc = 8'd3; tick("R7 arm");
        run_exec("R7 walk", 14'h46);
        s_lw = 1; s_ls = 14'h42; s_le = 14'h47; s_lc = 8'd5;
        run_exec("R7 collide old redirect", 14'h47);
        for (int i = 0; i < 6; i++) run_exec("R7 walk new", pc);
        run_exec("R7 new start used", 14'h47);
        s_lw = 1; s_lc = 8'd0; tick("R7 disarm");
        // above window
        run_exec("R4 branch out", 14'h60);
        run_exec("R4 fault cycle exec ignored", 14'h70);
        run_exec("R9 frozen", 14'h30);
        tick("R9 frozen idle");
        s_st = 1; s_sa = 16'h0108; tick("R2 restart clears");
        s_sm = 1; run_exec("R8 step trap", 14'h42);
        run_exec("R9 frozen after trap", 14'h50);
        // lower bound and exact upper bound
        s_st = 1; s_sa = 16'h007C; tick("R2 start below window");
        tick("R4 below lower bound");
        s_st = 1; s_sa = 16'h0080; tick("R2 start at lower bound");
        tick("R4 lower bound legal");
        s_st = 1; s_sa = 16'h013C; tick("R2 start at top word");
        run_exec("R4 top word legal", 14'h4F);
        tick("R4 past upper bound");
        s_st = 1; s_sa = 16'h0100; s_ev = 1; s_np = 14'h10; tick("R2 start wins over exec");
        repeat (3) @(posedge clk);
        #1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule